// File: doc/BRIEF.md
# Ethernet receive address filter and header parser

This block sits behind an Ethernet controller that delivers each received frame as a byte stream. The stream begins at the destination MAC address, with no preamble or start-of-frame delimiter, and it carries the four CRC bytes at its tail. The controller's own address filter compares only the first five bytes of the destination address. This block finishes that check: it compares byte index 5 with the local node's address byte. A frame that fails the check is consumed and discarded.

For a frame that passes, the 14 Ethernet header bytes are dropped. This includes the length field, which is never interpreted. The next two bytes are taken as the application header: first the physical address, then the packet type. They are presented on registered outputs together with a one-cycle header strobe. The bytes that follow, up to the CRC, go out on a byte stream with a last flag. A four-byte delay line holds back the CRC so that the last flag lands on the final payload byte. A frame too short to hold the headers, one payload byte and the CRC (fewer than 21 bytes) is dropped as a runt. Every dropped frame advances a wrapping counter.

Top module: `eth_rx_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, hdr_valid, pay_valid and pay_last are low and drop_count is 0. in_ready is low during reset and high from the first clock edge after reset is released.
- R2: Byte index 5 (0-based from the first destination byte) is compared with local_addr. On a mismatch, the frame produces no hdr_valid and no pay_valid.
- R3: drop_count increases by exactly one, one cycle after the last byte of a dropped frame (address mismatch or runt) is accepted. It wraps at its width and changes at no other time.
- R4: For a frame that matches, hdr_phys takes byte index 14 and hdr_type takes byte index 15, one cycle after each byte is accepted. Both hold that value until the next matching frame reaches those bytes. Bytes 0 to 13 are never forwarded.
- R5: hdr_valid is a one-cycle pulse, one cycle after byte index 19 of a matching frame is accepted, provided that byte is not the last. With continuous input, it comes exactly one cycle before the first payload byte.
- R6: For a matching frame of N bytes, bytes 16 to N-5 appear on pay_data in order. Each appears with pay_valid, one cycle after byte index i+4 of the same frame is accepted.
- R7: pay_last is high only together with byte index N-5. The last four bytes of a frame are never forwarded.
- R8: A frame whose last byte is at index 19 or earlier is a runt. It produces no hdr_valid and no pay_valid, and it is counted in drop_count.
- R9: in_ready stays high while a mismatching frame is discarded. The frame that follows a dropped one is filtered and parsed normally.
- R10: A byte is consumed only in a cycle where in_valid and in_ready are both high. Idle cycles between bytes do not change what is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_addr | input | 8 | Last byte of this node's MAC address |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Received frame byte |
| in_last | input | 1 | Marks the frame's final byte (last CRC byte) |
| in_ready | output | 1 | Block accepts input |
| hdr_valid | output | 1 | One-cycle strobe: application header is ready |
| hdr_phys | output | 8 | Intended physical address (data byte 0) |
| hdr_type | output | 8 | Packet type (data byte 1) |
| pay_valid | output | 1 | Payload byte present |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte of the frame |
| drop_count | output | CNT_W | Wrapping count of dropped frames |

## Verification
The hardest situations to reach are the length boundaries, because they sit exactly where the delay line fills and empties. A 20-byte frame must be a runt with no header strobe. A 21-byte frame must yield a header and a single payload byte, with last set on it. The stimulus sends frames of exactly these lengths back to back with full-size frames, and with mismatching frames that end at byte 5 itself. A cycle-level model in the bench predicts every output, so a stale byte left in the delay line from the previous frame would show up at once. Frames are also sent with idle gaps inserted between bytes, to show that the result depends only on the bytes that are accepted.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
    localparam int BYTE_W       = 8;
    localparam int ETH_HDR      = 14;   // dst MAC, src MAC, length
    localparam int APP_HDR      = 2;    // physical address, packet type
    localparam int CRC_BYTES    = 4;
    localparam int MAC_TAIL_IDX = 5;    // only byte not checked upstream
    localparam int PAY_IDX      = ETH_HDR + APP_HDR;
    localparam int POS_SAT      = PAY_IDX + CRC_BYTES;
    localparam int POS_W        = $clog2(POS_SAT + 1);

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam pos_t P_ADDR = pos_t'(MAC_TAIL_IDX);
    localparam pos_t P_PHYS = pos_t'(ETH_HDR);
    localparam pos_t P_TYPE = pos_t'(ETH_HDR + 1);
    localparam pos_t P_PAY  = pos_t'(PAY_IDX);
    localparam pos_t P_HDRV = pos_t'(POS_SAT - 1);
    localparam pos_t P_SAT  = pos_t'(POS_SAT);

    typedef struct packed {
        logic  ready;
        logic  skip;
        logic  hdr_valid;
        byte_t phys;
        byte_t ptype;
        logic  pay_valid;
        byte_t pay_data;
        logic  pay_last;
    } rx_state_t;
endpackage

// File: rtl/eth_rx_pos.sv
module eth_rx_pos
    import eth_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    output pos_t pos
);
    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (step) begin
            if (clear)
                pos_d = '0;
            else if (pos_q != P_SAT)
                pos_d = pos_q + pos_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign pos = pos_q;
endmodule

// File: rtl/eth_rx_delay.sv
module eth_rx_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [DEPTH];
    logic [W-1:0] stage_q [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            always_comb stage_d[k] = shift ? din : stage_q[k];
        end else begin : g_body
            always_comb stage_d[k] = shift ? stage_q[k-1] : stage_q[k];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[k] <= '0;
            else        stage_q[k] <= stage_d[k];
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
    import eth_rx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       local_addr,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             hdr_valid,
    output logic [7:0]       hdr_phys,
    output logic [7:0]       hdr_type,
    output logic             pay_valid,
    output logic [7:0]       pay_data,
    output logic             pay_last,
    output logic [CNT_W-1:0] drop_count
);
    rx_state_t        st_d, st_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    pos_t             pos;
    byte_t            dly_out;
    logic             accept, mism, drop, shift;

    eth_rx_pos u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (accept),
        .clear (in_last),
        .pos   (pos)
    );

    eth_rx_delay #(.W(BYTE_W), .DEPTH(CRC_BYTES)) u_crc_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (shift),
        .din   (in_data),
        .dout  (dly_out)
    );

    always_comb begin
        accept = in_valid && st_q.ready;
        mism   = accept && (pos == P_ADDR) && (in_data != local_addr);
        drop   = st_q.skip || mism;
        shift  = 1'b0;
        cnt_d  = cnt_q;
        st_d           = st_q;
        st_d.ready     = 1'b1;
        st_d.hdr_valid = 1'b0;
        st_d.pay_valid = 1'b0;
        st_d.pay_last  = 1'b0;
        if (accept) begin
            if (mism) st_d.skip = 1'b1;
            if (!drop) begin
                if (pos == P_PHYS) st_d.phys  = in_data;
                if (pos == P_TYPE) st_d.ptype = in_data;
                if (pos >= P_PAY)  shift = 1'b1;
                if (pos == P_HDRV && !in_last) st_d.hdr_valid = 1'b1;
                if (pos == P_SAT) begin
                    st_d.pay_valid = 1'b1;
                    st_d.pay_data  = dly_out;
                    st_d.pay_last  = in_last;
                end
            end
            if (in_last) begin
                st_d.skip = 1'b0;
                if (drop || pos < P_SAT) cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign in_ready   = st_q.ready;
    assign hdr_valid  = st_q.hdr_valid;
    assign hdr_phys   = st_q.phys;
    assign hdr_type   = st_q.ptype;
    assign pay_valid  = st_q.pay_valid;
    assign pay_data   = st_q.pay_data;
    assign pay_last   = st_q.pay_last;
    assign drop_count = cnt_q;
endmodule

// File: rtl/eth_rx_filter_chk.sv
module eth_rx_filter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             hdr_valid,
    input logic             pay_valid,
    input logic             pay_last,
    input logic [CNT_W-1:0] drop_count
);
    p_last_with_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pay_last |-> pay_valid);

    p_hdr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> !hdr_valid);

    p_hdr_not_with_pay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> !pay_valid);

    p_ready_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready);

    p_drop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drop_count) |-> (drop_count == $past(drop_count) + 1'b1));

    p_pay_from_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> $past(in_valid && in_ready));
endmodule

bind eth_rx_filter eth_rx_filter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .hdr_valid  (hdr_valid),
    .pay_valid  (pay_valid),
    .pay_last   (pay_last),
    .drop_count (drop_count)
);

// File: tb/tb_eth_rx_filter.sv
`timescale 1ns/1ps
module tb_eth_rx_filter;
    localparam int CNT_W = 16;

    logic clk = 0, rst_n = 0;
    logic [7:0] local_addr = 8'h5A;
    logic in_valid = 0, in_last = 0;
    logic [7:0] in_data = 0;
    logic in_ready, hdr_valid, pay_valid, pay_last;
    logic [7:0] hdr_phys, hdr_type, pay_data;
    logic [CNT_W-1:0] drop_count;

    always #4 clk = ~clk;

    eth_rx_filter #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .local_addr(local_addr),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .hdr_valid(hdr_valid), .hdr_phys(hdr_phys),
        .hdr_type(hdr_type), .pay_valid(pay_valid), .pay_data(pay_data),
        .pay_last(pay_last), .drop_count(drop_count)
    );

    int errors = 0, checks = 0;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    logic m_ready = 0, m_skip = 0, m_hdr = 0, m_pv = 0, m_pl = 0;
    logic [7:0] m_phys = 0, m_type = 0, m_pd = 0;
    int m_idx = 0, m_drops = 0;
    byte unsigned m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ready = 0; m_skip = 0; m_hdr = 0; m_pv = 0; m_pl = 0;
            m_phys = 0; m_type = 0; m_pd = 0; m_idx = 0; m_drops = 0;
            m_q.delete();
        end else begin
            logic acc;
            acc = in_valid && m_ready;
            m_hdr = 0; m_pv = 0; m_pl = 0;
            if (acc) begin
                if (m_idx == 5 && in_data != local_addr) m_skip = 1;
                if (!m_skip) begin
                    if (m_idx == 14) m_phys = in_data;
                    if (m_idx == 15) m_type = in_data;
                    if (m_idx == 19 && !in_last) m_hdr = 1;
                    if (m_idx >= 20) begin
                        m_pv = 1; m_pd = m_q.pop_front(); m_pl = in_last;
                    end
                    if (m_idx >= 16) m_q.push_back(in_data);
                end
                if (in_last) begin
                    if (m_skip || m_idx < 20) m_drops++;
                    m_skip = 0; m_idx = 0; m_q.delete();
                end else m_idx++;
            end
            m_ready = 1;
        end
    end

    int pay_seen = 0, hdr_seen = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(in_ready == m_ready, "R9 in_ready", in_ready, m_ready);
            check(hdr_valid == m_hdr, "R5 hdr_valid", hdr_valid, m_hdr);
            check(hdr_phys == m_phys, "R4 hdr_phys", hdr_phys, m_phys);
            check(hdr_type == m_type, "R4 hdr_type", hdr_type, m_type);
            check(pay_valid == m_pv, "R6 pay_valid", pay_valid, m_pv);
            if (m_pv) check(pay_data == m_pd, "R6 pay_data", pay_data, m_pd);
            check(pay_last == m_pl, "R7 pay_last", pay_last, m_pl);
            check(drop_count == CNT_W'(m_drops), "R3 drop_count", drop_count, m_drops);
            if (pay_valid) pay_seen++;
            if (hdr_valid) hdr_seen++;
        end
    end

    int gap_mode = 0;
    int unsigned seed = 32'h1234_5678;

    task automatic send_frame(input int len, input logic [7:0] tail, input int tag);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1;
            in_data  = (i == 5) ? tail : 8'((tag * 37 + i * 11) ^ (i >> 3));
            in_last  = (i == len - 1);
            @(negedge clk);
            in_valid = 0; in_last = 0;
            if (gap_mode != 0) begin
                seed = seed * 1103515245 + 12345;
                repeat (seed[17:16]) @(negedge clk);
            end
            // re-align: next iteration waits one negedge before driving
        end
    endtask

    // continuous variant: drive on consecutive cycles
    task automatic send_burst(input int len, input logic [7:0] tail, input int tag);
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            in_valid = 1;
            in_data  = (i == 5) ? tail : 8'((tag * 37 + i * 11) ^ (i >> 3));
            in_last  = (i == len - 1);
            @(negedge clk);
        end
        in_valid = 0; in_last = 0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int p0, h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(in_ready == 0, "R1 ready in reset", in_ready, 0);
        check(hdr_valid == 0 && pay_valid == 0 && pay_last == 0, "R1 strobes", pay_valid, 0);
        check(drop_count == 0, "R1 drop_count", drop_count, 0);
        rst_n = 1;
        @(negedge clk);
        check(in_ready == 1, "R1 ready after reset", in_ready, 1);
        check(pay_valid == 0 && drop_count == 0, "R1 idle after reset", pay_valid, 0);

        // continuous good frame
        p0 = pay_seen; h0 = hdr_seen;
        send_burst(64, local_addr, 1); settle();
        check(pay_seen - p0 == 44, "R6 payload count 64B", pay_seen - p0, 44);
        check(hdr_seen - h0 == 1, "R5 header once", hdr_seen - h0, 1);

        // R2: mismatching frame, then R9 recovery
        p0 = pay_seen; h0 = hdr_seen;
        send_burst(64, local_addr ^ 8'h01, 2); settle();
        check(pay_seen - p0 == 0 && hdr_seen == h0, "R2 mismatch forwards nothing", pay_seen - p0, 0);
        check(drop_count == 1, "R2 mismatch counted", drop_count, 1);
        p0 = pay_seen;
        send_burst(60, local_addr, 3); settle();
        check(pay_seen - p0 == 40, "R9 recovery after skip", pay_seen - p0, 40);

        // R8: runt boundaries
        p0 = pay_seen; h0 = hdr_seen;
        send_burst(20, local_addr, 4); settle();
        send_burst(15, local_addr, 5); settle();
        check(pay_seen == p0 && hdr_seen == h0, "R8 runts forward nothing", pay_seen - p0, 0);
        check(drop_count == 3, "R8 runts counted", drop_count, 3);
        p0 = pay_seen;
        send_burst(21, local_addr, 6); settle();
        check(pay_seen - p0 == 1, "R7 single payload byte", pay_seen - p0, 1);
        // mismatch ending at byte 5 itself
        send_burst(6, 8'h00, 7); settle();
        check(drop_count == 4, "R3 short mismatch counted once", drop_count, 4);

        // back to back frames, different local address
        local_addr = 8'hC3;
        @(negedge clk);
        p0 = pay_seen;
        send_burst(30, 8'hC3, 8);
        send_burst(25, 8'h5A, 9);
        send_burst(40, 8'hC3, 10); settle();
        check(pay_seen - p0 == 10 + 20, "R4 back-to-back frames", pay_seen - p0, 30);

        // R10: gapped input
        gap_mode = 1;
        p0 = pay_seen;
        send_frame(70, 8'hC3, 11);
        send_frame(22, 8'hC3, 12);
        send_frame(30, 8'h11, 13);
        send_frame(12, 8'hC3, 14); settle();
        check(pay_seen - p0 == 50 + 2, "R10 gapped payload count", pay_seen - p0, 52);
        check(drop_count == 7, "R10 gapped drops", drop_count, 7);

        settle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule